// File: doc/BRIEF.md
# SPI Interrupt Status Unit

This block holds the interrupt state of an SPI master that has a transmit FIFO and a receive FIFO. It keeps a seven-bit status word. Three of its bits are sticky event flags: transmit underflow, receive overflow and mode fail. The other four are level flags, rebuilt on every clock from the FIFO occupancy counts, the FIFO full flags and two programmable thresholds. A mask selects which status bits reach the single level-sensitive interrupt line.

Software reaches the block through a small register port with separate read and write strobes. Writing the enable register sets bits in the mask, and writing the disable register clears bits in it. Writing ones to the status register clears those status bits, and reading the status register clears the whole word. While the controller runs its linear read mode, a dedicated input freezes the status word. The FIFOs, the shifter and the chip selects are outside this block.

Top module: `spi_irq_unit`

## Requirements
- R1: Status bit positions are: 0 receive overflow, 1 mode fail, 2 transmit below threshold, 3 transmit full, 4 receive at or above threshold, 5 receive full, 6 transmit underflow. `irq` is high exactly when some bit is set in both the mask and the status word.
- R2: A one-cycle pulse on `rx_overflow_ev`, `mode_fail_ev` or `tx_underflow_ev` sets its status bit (0, 1 or 6) on the next edge. The bit stays set until it is cleared.
- R3: If an event pulse arrives in the same cycle as a clear by read or by write-one, the event wins and its bit is set after that edge.
- R4: Bit 4 equals (`rx_level` >= receive threshold). Bit 5 follows `rx_full` and bit 3 follows `tx_full`. All three are sampled one edge earlier.
- R5: Bit 2 equals (`tx_level` < transmit threshold), sampled one edge earlier.
- R6: The transmit threshold (select 4) and the receive threshold (select 5) both reset to 1. Each is written from `bus_wdata[CNT_W-1:0]` and reads back the written value.
- R7: Writing select 1 ORs `bus_wdata[6:0]` into the mask. Writing select 2 clears those bits from the mask. Select 3 reads the mask and ignores writes. Selects 1 and 2 read as zero.
- R8: Writing select 0 clears every status bit whose `bus_wdata` bit is 1. Level bits are rebuilt on the same edge.
- R9: Reading select 0 returns the status word zero-extended, in the same cycle. The edge that ends the read clears all sticky bits.
- R10: While `linear_mode` is high, no status bit can be set: event pulses are dropped and level bits hold. Clears by read or by write-one still apply.
- R11: After reset the mask and the status word are zero and `irq` is low. From the first edge after reset, the level bits follow R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register select |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| rx_level | input | CNT_W | Receive FIFO occupancy |
| tx_level | input | CNT_W | Transmit FIFO occupancy |
| rx_full | input | 1 | Receive FIFO full |
| tx_full | input | 1 | Transmit FIFO full |
| tx_underflow_ev | input | 1 | Transmit underflow event pulse |
| rx_overflow_ev | input | 1 | Receive overflow event pulse |
| mode_fail_ev | input | 1 | Mode fail event pulse |
| linear_mode | input | 1 | Freezes status updates while high |
| irq | output | 1 | Level interrupt |

## Verification
Two functions of this block can fall on the same edge: a sticky event pulse and a clear of that bit from software. The bench provokes the collision twice. In the first case it raises `rx_overflow_ev` during a status read. In the second it raises `tx_underflow_ev` during a write of all ones to the status register. Each time, the read value in that cycle must show the word before the edge, and the following status read must show the event bit still set.

// File: rtl/spi_irq_pkg.sv
package spi_irq_pkg;

    localparam int IRQ_W  = 7;
    localparam int REG_AW = 3;

    localparam int B_RX_OVF    = 0;
    localparam int B_MODE_FAIL = 1;
    localparam int B_TX_BELOW  = 2;
    localparam int B_TX_FULL   = 3;
    localparam int B_RX_ABOVE  = 4;
    localparam int B_RX_FULL   = 5;
    localparam int B_TX_UDF    = 6;

    localparam logic [IRQ_W-1:0] STICKY_BITS = 7'h43;
    localparam logic [IRQ_W-1:0] IRQ_VALID   = 7'h7F;

    typedef enum logic [REG_AW-1:0] {
        RS_STATUS  = 3'd0,
        RS_ENABLE  = 3'd1,
        RS_DISABLE = 3'd2,
        RS_MASK    = 3'd3,
        RS_TX_THR  = 3'd4,
        RS_RX_THR  = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic tx_udf;
        logic rx_ovf;
        logic mode_fail;
    } sticky_ev_t;

    typedef struct packed {
        logic rx_full;
        logic rx_above;
        logic tx_full;
        logic tx_below;
    } level_t;

    function automatic logic [IRQ_W-1:0] ev_to_bits(sticky_ev_t e);
        logic [IRQ_W-1:0] b;
        b = '0;
        b[B_TX_UDF]    = e.tx_udf;
        b[B_RX_OVF]    = e.rx_ovf;
        b[B_MODE_FAIL] = e.mode_fail;
        return b;
    endfunction

    function automatic logic [IRQ_W-1:0] level_to_bits(level_t l);
        logic [IRQ_W-1:0] b;
        b = '0;
        b[B_RX_FULL]  = l.rx_full;
        b[B_RX_ABOVE] = l.rx_above;
        b[B_TX_FULL]  = l.tx_full;
        b[B_TX_BELOW] = l.tx_below;
        return b;
    endfunction

endpackage

// File: rtl/spi_irq_level.sv
module spi_irq_level
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] rx_level,
    input  logic [CNT_W-1:0] tx_level,
    input  logic [CNT_W-1:0] rx_thr,
    input  logic [CNT_W-1:0] tx_thr,
    input  logic             rx_full,
    input  logic             tx_full,
    output level_t           lvl
);
    always_comb begin
        lvl.rx_full  = rx_full;
        lvl.tx_full  = tx_full;
        lvl.rx_above = (rx_level >= rx_thr);
        lvl.tx_below = (tx_level < tx_thr);
    end
endmodule

// File: rtl/spi_irq_ctrlregs.sv
module spi_irq_ctrlregs
    import spi_irq_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [IRQ_W-1:0] wr_bits,
    input  logic [CNT_W-1:0] wr_thr,
    output logic [IRQ_W-1:0] mask_q,
    output logic [CNT_W-1:0] tx_thr_q,
    output logic [CNT_W-1:0] rx_thr_q
);
    localparam logic [CNT_W-1:0] THR_RESET = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q   <= '0;
            tx_thr_q <= THR_RESET;
            rx_thr_q <= THR_RESET;
        end else if (wr_en) begin
            case (sel)
                RS_ENABLE:  mask_q   <= mask_q | (wr_bits & IRQ_VALID);
                RS_DISABLE: mask_q   <= mask_q & ~wr_bits;
                RS_TX_THR:  tx_thr_q <= wr_thr;
                RS_RX_THR:  rx_thr_q <= wr_thr;
                default: ;
            endcase
        end
    end

    assert_enable_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_ENABLE) |=>
            ((mask_q & $past(wr_bits)) == $past(wr_bits)) &&
            ((mask_q & $past(mask_q)) == $past(mask_q)));

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_DISABLE) |=> ((mask_q & $past(wr_bits)) == '0));

    assert_mask_only_via_en_R7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (sel == RS_ENABLE || sel == RS_DISABLE)) |=> $stable(mask_q));

    assert_rx_thr_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_RX_THR) |=> (rx_thr_q == $past(wr_thr)));

    assert_tx_thr_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == RS_TX_THR) |=> (tx_thr_q == $past(wr_thr)));
endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [IRQ_W-1:0] lvl_bits,
    input  logic [IRQ_W-1:0] ev_bits,
    input  logic [IRQ_W-1:0] clr_bits,
    output logic [IRQ_W-1:0] status_q
);
    logic [IRQ_W-1:0] status_d;

    for (genvar i = 0; i < IRQ_W; i++) begin : g_bit
        if (STICKY_BITS[i]) begin : g_sticky
            assign status_d[i] = freeze ? (status_q[i] & ~clr_bits[i])
                                        : ((status_q[i] & ~clr_bits[i]) | ev_bits[i]);

            assert_event_sets_R3: assert property (@(posedge clk) disable iff (rst)
                (!freeze && ev_bits[i]) |=> status_q[i]);

            assert_sticky_holds_R2: assert property (@(posedge clk) disable iff (rst)
                (!freeze && status_q[i] && !clr_bits[i]) |=> status_q[i]);
        end else begin : g_level
            assign status_d[i] = freeze ? (status_q[i] & ~clr_bits[i]) : lvl_bits[i];

            assert_level_tracks_R4: assert property (@(posedge clk) disable iff (rst)
                !freeze |=> (status_q[i] == $past(lvl_bits[i])));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

    assert_frozen_no_set_R10: assert property (@(posedge clk) disable iff (rst)
        freeze |=> ((status_q & ~$past(status_q)) == '0));
endmodule

// File: rtl/spi_irq_unit.sv
module spi_irq_unit
    import spi_irq_pkg::*;
#(
    parameter int FIFO_DEPTH = 32,
    parameter int DATA_W     = 32,
    localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [REG_AW-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  rx_level,
    input  logic [CNT_W-1:0]  tx_level,
    input  logic              rx_full,
    input  logic              tx_full,
    input  logic              tx_underflow_ev,
    input  logic              rx_overflow_ev,
    input  logic              mode_fail_ev,
    input  logic              linear_mode,
    output logic              irq
);
    localparam int USED_W = (IRQ_W > CNT_W) ? IRQ_W : CNT_W;

    reg_sel_e         sel;
    logic [IRQ_W-1:0] mask_q;
    logic [CNT_W-1:0] tx_thr_q;
    logic [CNT_W-1:0] rx_thr_q;
    logic [IRQ_W-1:0] status_q;
    logic [IRQ_W-1:0] clr_bits;
    logic [IRQ_W-1:0] ev_bits;
    level_t           lvl;
    sticky_ev_t       ev;
    logic             unused_wdata_hi;

    assign sel             = reg_sel_e'(bus_addr);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_W];

    always_comb begin
        ev.tx_udf    = tx_underflow_ev;
        ev.rx_ovf    = rx_overflow_ev;
        ev.mode_fail = mode_fail_ev;
    end
    assign ev_bits = ev_to_bits(ev);

    always_comb begin
        clr_bits = '0;
        if (bus_rd && sel == RS_STATUS) clr_bits = clr_bits | IRQ_VALID;
        if (bus_wr && sel == RS_STATUS) clr_bits = clr_bits | bus_wdata[IRQ_W-1:0];
    end

    spi_irq_ctrlregs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .sel      (sel),
        .wr_bits  (bus_wdata[IRQ_W-1:0]),
        .wr_thr   (bus_wdata[CNT_W-1:0]),
        .mask_q   (mask_q),
        .tx_thr_q (tx_thr_q),
        .rx_thr_q (rx_thr_q)
    );

    spi_irq_level #(.CNT_W(CNT_W)) u_level (
        .rx_level (rx_level),
        .tx_level (tx_level),
        .rx_thr   (rx_thr_q),
        .tx_thr   (tx_thr_q),
        .rx_full  (rx_full),
        .tx_full  (tx_full),
        .lvl      (lvl)
    );

    spi_irq_status u_status (
        .clk      (clk),
        .rst      (rst),
        .freeze   (linear_mode),
        .lvl_bits (level_to_bits(lvl)),
        .ev_bits  (ev_bits),
        .clr_bits (clr_bits),
        .status_q (status_q)
    );

    always_comb begin
        case (sel)
            RS_STATUS: bus_rdata = DATA_W'(status_q);
            RS_MASK:   bus_rdata = DATA_W'(mask_q);
            RS_TX_THR: bus_rdata = DATA_W'(tx_thr_q);
            RS_RX_THR: bus_rdata = DATA_W'(rx_thr_q);
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = |(mask_q & status_q & IRQ_VALID);

    assert_read_clears_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && sel == RS_STATUS && !linear_mode && ev_bits == '0)
            |=> ((status_q & STICKY_BITS) == '0));
endmodule

// File: tb/spi_irq_unit_tb.sv
module spi_irq_unit_tb;
    import spi_irq_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int FIFO_DEPTH = 32;
    localparam int DATA_W     = 32;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [REG_AW-1:0] bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [CNT_W-1:0]  rx_level = '0;
    logic [CNT_W-1:0]  tx_level = '0;
    logic              rx_full = 1'b0;
    logic              tx_full = 1'b0;
    logic              tx_underflow_ev = 1'b0;
    logic              rx_overflow_ev = 1'b0;
    logic              mode_fail_ev = 1'b0;
    logic              linear_mode = 1'b0;
    logic              irq;

    typedef struct {
        bit                is_irq;
        logic [DATA_W-1:0] exp;
        string             tag;
    } item_t;

    item_t sb_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_irq_unit #(.FIFO_DEPTH(FIFO_DEPTH), .DATA_W(DATA_W)) u_dut (
        .clk             (clk),
        .rst             (rst),
        .bus_addr        (bus_addr),
        .bus_wr          (bus_wr),
        .bus_rd          (bus_rd),
        .bus_wdata       (bus_wdata),
        .bus_rdata       (bus_rdata),
        .rx_level        (rx_level),
        .tx_level        (tx_level),
        .rx_full         (rx_full),
        .tx_full         (tx_full),
        .tx_underflow_ev (tx_underflow_ev),
        .rx_overflow_ev  (rx_overflow_ev),
        .mode_fail_ev    (mode_fail_ev),
        .linear_mode     (linear_mode),
        .irq             (irq)
    );

    // Monitor: compares queued expectations a quarter period after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD / 4);
            while (sb_q.size() > 0) begin
                item_t             it;
                logic [DATA_W-1:0] act;
                it  = sb_q.pop_front();
                act = it.is_irq ? DATA_W'(irq) : bus_rdata;
                n_checks++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_write(reg_sel_e s, logic [DATA_W-1:0] d);
        bus_addr  = s;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic reg_read(reg_sel_e s, logic [DATA_W-1:0] exp, string tag);
        bus_addr = s;
        bus_rd   = 1'b1;
        sb_q.push_back('{1'b0, exp, tag});
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic irq_expect(bit e, string tag);
        sb_q.push_back('{1'b1, DATA_W'(e), tag});
    endtask

    task automatic pulse(logic udf, logic ovf, logic mf);
        tx_underflow_ev = udf;
        rx_overflow_ev  = ovf;
        mode_fail_ev    = mf;
        @(negedge clk);
        tx_underflow_ev = 1'b0;
        rx_overflow_ev  = 1'b0;
        mode_fail_ev    = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(2);

        // Reset state
        reg_read(RS_MASK, 32'h0, "R11 mask after reset");
        irq_expect(1'b0, "R11 irq after reset");
        reg_read(RS_TX_THR, 32'h1, "R6 tx threshold reset");
        reg_read(RS_RX_THR, 32'h1, "R6 rx threshold reset");
        reg_read(RS_STATUS, 32'h04, "R11 R5 status after reset");
        reg_read(RS_STATUS, 32'h04, "R9 level bits rebuilt after read");

        // Level flags against default thresholds
        rx_level = 1; idle(1);
        reg_read(RS_STATUS, 32'h14, "R4 rx at threshold");
        rx_level = 0; tx_level = 1; idle(1);
        reg_read(RS_STATUS, 32'h00, "R5 tx at threshold");

        // Programmed thresholds and boundaries
        reg_write(RS_RX_THR, 32'd5);
        reg_write(RS_TX_THR, 32'd3);
        rx_level = 4; tx_level = 2; idle(1);
        reg_read(RS_STATUS, 32'h04, "R4 R5 one below thresholds");
        reg_read(RS_RX_THR, 32'd5, "R6 rx threshold readback");
        reg_read(RS_TX_THR, 32'd3, "R6 tx threshold readback");
        rx_level = 5; tx_level = 3; idle(1);
        reg_read(RS_STATUS, 32'h10, "R4 R5 at thresholds");
        rx_full = 1'b1; tx_full = 1'b1; idle(1);
        reg_read(RS_STATUS, 32'h38, "R4 full flags");
        rx_full = 1'b0; tx_full = 1'b0; rx_level = 0; tx_level = 0; idle(1);

        // Sticky events and read clear
        pulse(1'b0, 1'b1, 1'b0);
        idle(2);
        reg_read(RS_STATUS, 32'h05, "R2 overflow held");
        reg_read(RS_STATUS, 32'h04, "R9 sticky cleared by read");

        // Write-one clear
        pulse(1'b1, 1'b0, 1'b1);
        reg_write(RS_STATUS, 32'h02);
        reg_read(RS_STATUS, 32'h44, "R8 only mode fail cleared");
        reg_write(RS_STATUS, 32'h40);
        reg_read(RS_STATUS, 32'h04, "R8 underflow cleared");

        // Collision: event during read clear
        bus_addr = RS_STATUS; bus_rd = 1'b1; rx_overflow_ev = 1'b1;
        sb_q.push_back('{1'b0, 32'h04, "R3 read value before colliding event"});
        @(negedge clk);
        bus_rd = 1'b0; rx_overflow_ev = 1'b0;
        reg_read(RS_STATUS, 32'h05, "R3 event wins over read clear");

        // Collision: event during write-one clear
        bus_addr = RS_STATUS; bus_wdata = 32'h7F; bus_wr = 1'b1; tx_underflow_ev = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tx_underflow_ev = 1'b0;
        reg_read(RS_STATUS, 32'h44, "R3 event wins over write clear");

        // Mask and interrupt line
        pulse(1'b0, 1'b1, 1'b0);
        irq_expect(1'b0, "R1 status bit masked");
        reg_write(RS_ENABLE, 32'h01);
        irq_expect(1'b1, "R1 enabled bit raises irq");
        reg_read(RS_MASK, 32'h01, "R7 enable sets mask");
        reg_write(RS_MASK, 32'h7F);
        reg_read(RS_MASK, 32'h01, "R7 mask register ignores writes");
        reg_read(RS_ENABLE, 32'h0, "R7 enable reads zero");
        reg_read(RS_DISABLE, 32'h0, "R7 disable reads zero");
        reg_write(RS_DISABLE, 32'h01);
        irq_expect(1'b0, "R7 disable drops irq");
        reg_write(RS_ENABLE, 32'hFFFF_FF84);
        reg_read(RS_MASK, 32'h04, "R7 enable keeps only seven bits");
        irq_expect(1'b1, "R1 level bit raises irq");
        tx_level = 3; idle(1);
        irq_expect(1'b0, "R1 R5 irq follows level");

        // Linear mode freeze
        reg_write(RS_DISABLE, 32'h7F);
        linear_mode = 1'b1; idle(1);
        pulse(1'b1, 1'b0, 1'b0);
        rx_level = 7; idle(2);
        reg_read(RS_STATUS, 32'h01, "R10 status frozen");
        reg_read(RS_STATUS, 32'h00, "R10 read clear applies while frozen");
        linear_mode = 1'b0; idle(1);
        reg_read(RS_STATUS, 32'h10, "R10 updates resume, dropped event absent");

        idle(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule